// File: doc/BRIEF.md
# GPIO Pin-Edge Interrupt Controller

This block watches a bank of general-purpose input ports and raises a single interrupt request when any pin it is configured to watch changes in the selected way. Each pin has an enable bit and a two-bit detection code, with one bit of the code held in each of two per-port mode registers. A pin can be set to catch a rising edge, a falling edge, or any difference from the level seen at the last read of its port. Software configures the block and reads port levels over a simple register bus.

All per-pin interrupt outputs are ORed into one shared line. The request flop is set on the rising edge of that line, and only while the GPIO mask bit is set. While any source stays asserted, the line cannot rise again. A pin therefore has to be serviced, either by reading its port or by restoring its level, before any further GPIO request can be raised. A global enable bit gates the request flop onto the output, and an acknowledge input clears the flop.

Register map. Port `p` occupies addresses `4p` to `4p+3`:
- offset 0: pin levels (read only)
- offset 1: enable
- offset 2: mode low bits
- offset 3: mode high bits

The global control register sits at address `4*NUM_PORTS`. Bit 0 of that register is the GPIO mask and bit 1 is the global enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every enable, mode and global bit reads 0, `irq` is 0, and `rdData` is 0.
- R2: A write stores `wrData` into the addressed enable, mode or global register. A read presents the addressed register on `rdData` one cycle after `rdEn`, and `rdData` holds its value when no read is made. In the global register, bit 0 is the mask, bit 1 is the global enable, and all other bits read 0.
- R3: Reading offset 0 of a port returns its pin levels after a two-flop synchronizer. The same read also loads those levels into the port's reference register.
- R4: Code 01 (mode-high bit 0, mode-low bit 1) sets a sticky flag on a rising pin edge. With mask and global enable set, `irq` rises 4 cycles after the pin changes.
- R5: Code 10 (mode-high bit 1, mode-low bit 0) does the same for a falling pin edge, with the same 4-cycle latency.
- R6: Code 11 drives the pin output while the synchronized level differs from the reference captured at the last port read. `irq` rises 3 cycles after the pin changes.
- R7: A pin with code 00, or with its enable bit at 0, never contributes to the request.
- R8: The request flop is set only on a rising edge of the OR of all pin outputs. While any pin output stays high, a new source raises no request. Once all pin outputs have dropped, the next source raises one again.
- R9: With the mask bit at 0, an OR edge does not set the request flop. Setting the mask afterwards does not recover the missed edge.
- R10: `irq` equals the request flop gated by the global enable bit, and it follows a change of that bit in the cycle after the write.
- R11: `ack` clears the request flop in the next cycle, unless a new OR edge arrives in the same cycle.
- R12: A read of a port's offset 0 clears the sticky flags of that port only. A flag that is set in the same cycle as the read wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | NUM_PORTS*PORT_W | Asynchronous pin levels, port 0 in the low bits |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | PORT_W | Write data |
| rdData | output | PORT_W | Read data, valid the cycle after `rdEn` |
| ack | input | 1 | Interrupt acknowledge, clears the request flop |
| irq | output | 1 | Shared GPIO interrupt request |

## Verification
A pin change on a falling clock edge reaches the synchronized level two edges later, so change mode shows on `irq` at the third edge. Edge modes need one more edge for the sticky flag and show on `irq` at the fourth edge. Register reads are due one edge after `rdEn`, and an acknowledge or a global-enable write shows on `irq` one edge later. The bench records each expected value together with the exact cycle it is due in, checks it at the falling edge of that cycle, and also checks the cycle just before, so a result that arrives early or late is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  parameter int NUM_PORTS = 2;
  parameter int PORT_W    = 8;

  localparam int PIDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int HI_W       = $clog2(NUM_PORTS + 1);
  localparam int ADDR_W     = HI_W + 2;
  localparam int TOTAL_PINS = NUM_PORTS * PORT_W;
  localparam int GLB_MASK_BIT   = 0;
  localparam int GLB_ENABLE_BIT = 1;

  typedef enum logic [1:0] {
    SEL_DATA    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_MODE_LO = 2'd2,
    SEL_MODE_HI = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RISE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_CHANGE = 2'b11
  } edgeMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] wrEnable;
    logic [NUM_PORTS-1:0] wrModeLo;
    logic [NUM_PORTS-1:0] wrModeHi;
    logic [NUM_PORTS-1:0] rdCapture;
    logic [PIDX_W-1:0]    portIdx;
    logic [1:0]           sel;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TOTAL_PINS-1:0] pinIn,
  input  logic [PORT_W-1:0]     wrData,
  input  strobe_t               stb,
  output logic [TOTAL_PINS-1:0] pinOut,
  output logic [PORT_W-1:0]     rdWord
);
  logic [PORT_W-1:0] syncArr [NUM_PORTS];
  logic [PORT_W-1:0] enArr   [NUM_PORTS];
  logic [PORT_W-1:0] loArr   [NUM_PORTS];
  logic [PORT_W-1:0] hiArr   [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] syncA, syncB, prevLvl, refLvl, flags;
    logic [PORT_W-1:0] enReg, loReg, hiReg, riseHit, fallHit;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncA   <= '0;
        syncB   <= '0;
        prevLvl <= '0;
        refLvl  <= '0;
        flags   <= '0;
        enReg   <= '0;
        loReg   <= '0;
        hiReg   <= '0;
      end else begin
        syncA   <= pinIn[p*PORT_W +: PORT_W];
        syncB   <= syncA;
        prevLvl <= syncB;
        if (stb.rdCapture[p]) refLvl <= syncB;
        // new edges win over the read clear
        flags <= (stb.rdCapture[p] ? '0 : flags) | riseHit | fallHit;
        if (stb.wrEnable[p]) enReg <= wrData;
        if (stb.wrModeLo[p]) loReg <= wrData;
        if (stb.wrModeHi[p]) hiReg <= wrData;
      end
    end

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      edgeMode_e mode;
      assign mode       = edgeMode_e'({hiReg[b], loReg[b]});
      assign riseHit[b] = syncB[b] & ~prevLvl[b] & (mode == MODE_RISE);
      assign fallHit[b] = ~syncB[b] & prevLvl[b] & (mode == MODE_FALL);
      assign pinOut[p*PORT_W + b] = enReg[b] & (mode != MODE_OFF) &
          ((mode == MODE_CHANGE) ? (syncB[b] ^ refLvl[b]) : flags[b]);
    end

    assign syncArr[p] = syncB;
    assign enArr[p]   = enReg;
    assign loArr[p]   = loReg;
    assign hiArr[p]   = hiReg;
  end

  always_comb begin
    rdWord = '0;
    case (stb.sel)
      SEL_DATA:    rdWord = syncArr[stb.portIdx];
      SEL_ENABLE:  rdWord = enArr[stb.portIdx];
      SEL_MODE_LO: rdWord = loArr[stb.portIdx];
      SEL_MODE_HI: rdWord = hiArr[stb.portIdx];
      default:     rdWord = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [1:0]            glbData,
  input  logic                  ack,
  input  logic [TOTAL_PINS-1:0] pinOut,
  input  logic [PORT_W-1:0]     rdWord,
  output strobe_t               stb,
  output logic [PORT_W-1:0]     rdData,
  output logic                  irq,
  output logic                  anyOut,
  output logic                  setReq,
  output logic                  irqFlop,
  output logic                  gpioMask
);
  localparam logic [HI_W-1:0] GLB_IDX = HI_W'(NUM_PORTS);

  logic [HI_W-1:0] hiField;
  logic            isGlobal, inPort, globalEn, anyPrev;
  logic [PORT_W-1:0] glbWord;

  assign hiField  = addr[ADDR_W-1:2];
  assign isGlobal = (hiField == GLB_IDX);
  assign inPort   = (hiField < GLB_IDX);

  always_comb begin
    stb         = '0;
    stb.portIdx = hiField[PIDX_W-1:0];
    stb.sel     = addr[1:0];
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hiField == HI_W'(p)) begin
        stb.wrEnable[p]  = wrEn && (addr[1:0] == SEL_ENABLE);
        stb.wrModeLo[p]  = wrEn && (addr[1:0] == SEL_MODE_LO);
        stb.wrModeHi[p]  = wrEn && (addr[1:0] == SEL_MODE_HI);
        stb.rdCapture[p] = rdEn && (addr[1:0] == SEL_DATA);
      end
    end
  end

  always_comb begin
    glbWord = '0;
    glbWord[GLB_MASK_BIT]   = gpioMask;
    glbWord[GLB_ENABLE_BIT] = globalEn;
  end

  assign anyOut = |pinOut;
  assign setReq = gpioMask & anyOut & ~anyPrev;
  assign irq    = irqFlop & globalEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      gpioMask <= 1'b0;
      globalEn <= 1'b0;
      anyPrev  <= 1'b0;
      irqFlop  <= 1'b0;
      rdData   <= '0;
    end else begin
      anyPrev <= anyOut;
      if (wrEn && isGlobal) begin
        gpioMask <= glbData[GLB_MASK_BIT];
        globalEn <= glbData[GLB_ENABLE_BIT];
      end
      if (setReq)   irqFlop <= 1'b1;
      else if (ack) irqFlop <= 1'b0;
      if (rdEn) rdData <= isGlobal ? glbWord : (inPort ? rdWord : '0);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TOTAL_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [PORT_W-1:0]     wrData,
  output logic [PORT_W-1:0]     rdData,
  input  logic                  ack,
  output logic                  irq
);
  strobe_t               stb;
  logic [TOTAL_PINS-1:0] pinOut;
  logic [PORT_W-1:0]     rdWord;
  logic                  anyOut, setReq, irqFlop, gpioMask;

  gpio_irq_dp u_dp (
    .clk(clk), .rst(rst), .pinIn(pinIn), .wrData(wrData), .stb(stb),
    .pinOut(pinOut), .rdWord(rdWord)
  );

  gpio_irq_ctl u_ctl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .glbData(wrData[1:0]), .ack(ack), .pinOut(pinOut), .rdWord(rdWord),
    .stb(stb), .rdData(rdData), .irq(irq), .anyOut(anyOut),
    .setReq(setReq), .irqFlop(irqFlop), .gpioMask(gpioMask)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic              ack,
  input logic              anyOut,
  input logic              setReq,
  input logic              irqFlop,
  input logic              gpioMask,
  input logic [PORT_W-1:0] rdData
);
  a_r8_or_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (anyOut && !$past(anyOut) && gpioMask) |=> irqFlop);

  a_r8_held_blocks: assert property (@(posedge clk) disable iff (rst)
    $rose(irqFlop) |-> ($past(anyOut) && !$past(anyOut, 2)));

  a_r9_mask_needed: assert property (@(posedge clk) disable iff (rst)
    $rose(irqFlop) |-> $past(gpioMask));

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !setReq) |=> !irqFlop);

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rdEn) |-> $stable(rdData));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk chk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .ack(ack), .anyOut(anyOut),
  .setReq(setReq), .irqFlop(irqFlop), .gpioMask(gpioMask), .rdData(rdData)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  import gpio_irq_pkg::*;

  typedef struct {
    int         cyc;
    bit         isIrq;
    logic [7:0] val;
    string      req;
  } item_t;

  logic clk = 0, rst = 1, wrEn = 0, rdEn = 0, ack = 0;
  logic [TOTAL_PINS-1:0] pins = 16'h0002;
  logic [ADDR_W-1:0] addr = '0;
  logic [PORT_W-1:0] wrData = '0;
  logic [PORT_W-1:0] rdData;
  logic irq;
  int cycle = 0, nChecks = 0, nFails = 0;
  bit done = 0;
  item_t q[$];

  localparam logic [ADDR_W-1:0] GLB = ADDR_W'(NUM_PORTS * 4);

  gpio_irq_ctrl uut (
    .clk(clk), .rst(rst), .pinIn(pins), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .ack(ack), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  // monitor: compare every item whose cycle has come
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cycle) begin
        logic [7:0] act;
        act = q[i].isIrq ? {7'd0, irq} : rdData;
        nChecks++;
        if (q[i].cyc != cycle || act !== q[i].val) begin
          nFails++;
          $display("FAIL %s: %s actual %0h expected %0h (cycle %0d)", q[i].req,
                   q[i].isIrq ? "irq" : "rdData", act, q[i].val, q[i].cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectIrq(int dly, logic v, string req);
    q.push_back('{cycle + dly, 1'b1, {7'd0, v}, req});
  endtask

  task automatic busWrite(int a, logic [7:0] d);
    addr = ADDR_W'(a); wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic busRead(int a, logic [7:0] exp, string req);
    addr = ADDR_W'(a); rdEn = 1;
    q.push_back('{cycle + 1, 1'b0, exp, req});
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic doAck();
    ack = 1;
    expectIrq(1, 0, "R11");
    @(negedge clk);
    ack = 0;
  endtask

  // rising edge with exact due-cycle check
  task automatic riseEdge(int pin, logic expIrq, string req);
    pins[pin] = 0;
    step(3);
    pins[pin] = 1;
    expectIrq(3, 0, req);
    expectIrq(4, expIrq, req);
    step(5);
  endtask

  initial begin
    step(3);
    rst = 0;
    // R1: reset state
    expectIrq(1, 0, "R1");
    busRead(1, 8'h00, "R1");
    busRead(GLB, 8'h00, "R1");
    busRead(7, 8'h00, "R1");
    // R2: write and read back
    busWrite(1, 8'hA5);
    busRead(1, 8'hA5, "R2");
    busWrite(7, 8'h3C);
    busRead(7, 8'h3C, "R2");
    busWrite(GLB, 8'hFF);
    busRead(GLB, 8'h03, "R2");
    // port0: b0 rise, b1 fall, b2 change, b3 code 00, b4 rise but disabled
    busWrite(1, 8'h0F);
    busWrite(2, 8'h15);
    busWrite(3, 8'h06);
    // port1: b0 rise
    busWrite(5, 8'h01);
    busWrite(6, 8'h01);
    busWrite(7, 8'h00);
    // R3: synchronized levels, reference captured
    busRead(0, 8'h02, "R3");
    // R4: rising edge, irq due at +4
    pins[0] = 1;
    expectIrq(3, 0, "R4");
    expectIrq(4, 1, "R4");
    step(5);
    doAck();
    // R12: read clears the flag, so a later edge raises again
    busRead(0, 8'h03, "R12");
    // R5: falling edge
    pins[1] = 0;
    expectIrq(3, 0, "R5");
    expectIrq(4, 1, "R5");
    step(5);
    doAck();
    busRead(0, 8'h01, "R3");
    // R6: change since last read, due at +3
    pins[2] = 1;
    expectIrq(2, 0, "R6");
    expectIrq(3, 1, "R6");
    step(4);
    doAck();
    busRead(0, 8'h05, "R6");
    pins[2] = 0;
    expectIrq(2, 0, "R6");
    expectIrq(3, 1, "R6");
    step(4);
    doAck();
    busRead(0, 8'h01, "R6");
    // R7: code 00 and disabled pin
    pins[3] = 1;
    pins[4] = 1;
    expectIrq(4, 0, "R7");
    expectIrq(6, 0, "R7");
    step(7);
    // R8: held source blocks a later one
    pins[8] = 1;
    expectIrq(4, 1, "R8");
    step(5);
    doAck();
    riseEdge(0, 0, "R8");
    busRead(0, 8'h19, "R12");
    expectIrq(2, 0, "R12");
    step(3);
    busRead(4, 8'h01, "R12");
    riseEdge(0, 1, "R8");
    doAck();
    busRead(0, 8'h19, "R12");
    // R9: mask off drops the edge for good
    busWrite(GLB, 8'h02);
    riseEdge(0, 0, "R9");
    busWrite(GLB, 8'h03);
    expectIrq(2, 0, "R9");
    step(3);
    busRead(0, 8'h19, "R9");
    // R10: global enable gates the output
    busWrite(GLB, 8'h01);
    riseEdge(0, 0, "R10");
    expectIrq(1, 1, "R10");
    busWrite(GLB, 8'h03);
    expectIrq(1, 0, "R10");
    busWrite(GLB, 8'h01);
    expectIrq(1, 1, "R10");
    busWrite(GLB, 8'h03);
    doAck();
    busRead(0, 8'h19, "R10");
    step(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule